// File: doc/BRIEF.md
# Modular Multi-Modulus Integer Clock Divider

This block divides a fast input clock by a programmable integer. It is a chain of identical divide-by-two-or-three stages. Each stage passes one output tick to the next, slower stage for every two input ticks. In one of its own output periods per full divider cycle it may take three input ticks instead of two. A stage stretches its period only when two things hold at once: its own bit of the program word is set, and the slower neighbour signals through its modulus line that the stretch window is open. The number of stages `STAGES` (written n below) is a parameter. The ratio runs from 2^n up to 2^(n+1)-1.

The whole chain runs on one clock. Each slower stage advances on a clock enable that the faster stage beside it produces, so the design has no derived clocks. The program word is captured only at the boundary between two divider cycles, so every cycle runs at a single ratio. The output is a pulse one input clock wide, once per divider cycle. A phase detector or a counter can use it as the divided event.

Top module: `mmd_divider`

## Requirements
- R1: With the held program word P (unsigned, bit i weighted 2^i), the output pulses exactly once every 2^n + P input clock cycles.
- R2: Each output pulse is high for exactly one input clock cycle and is low in the cycle that follows it.
- R3: While `rst` is high on a rising edge, the output is low, every stage returns to its first phase and the program word is taken from `prog`. The first pulse after reset appears on the (2^n + P)-th rising edge after `rst` is released.
- R4: `prog` is sampled only on the rising edge that raises the output pulse, and during reset. A change at any other moment leaves the current cycle at its old ratio and applies from the next cycle.
- R5: P = 0 gives the smallest ratio, 2^n: every stage divides by two.
- R6: P with all n bits set gives the largest ratio, 2^(n+1)-1.
- R7: A word with only bit i set adds exactly 2^i input cycles over P = 0, because stage i takes one extra tick once per divider cycle.
- R8: A stage raises its modulus-out only in the last input tick of its own output period, and only while its own modulus-in is high. The slowest stage's modulus-in is held high. The end-of-cycle marker from the fastest stage therefore coincides with every stage wrapping to its first phase on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock that is divided |
| rst | input | 1 | Synchronous reset, active high |
| prog | input | STAGES | Program word P; ratio is 2^STAGES + P |
| div_out | output | 1 | Divided output, one clock wide per divider cycle |

## Verification
The hardest case to reach from the ports is a change of the program word that lands in the last input cycle before a pulse. That cycle is the boundary between loading the new word and leaving it for one more period. The stimulus waits a random number of cycles after each pulse before it changes `prog`, with the wait reaching up to one cycle short of the smallest period. It also directs a change into exactly the final cycle of the running period. Then it checks that the period in flight keeps its old length and that the next one takes the new length. A full sweep of every program word and a reset in the middle of a cycle cover the ratio endpoints and the first-pulse timing.

// File: rtl/mmd_pkg.sv
package mmd_pkg;

    // Phase of one divide-by-2/3 stage within its own output period.
    typedef enum logic [1:0] {
        PH_0 = 2'd0,
        PH_1 = 2'd1,
        PH_2 = 2'd2
    } cell_phase_t;

    // Division ratio for a given stage count and program word value.
    function automatic int unsigned mmd_ratio(input int unsigned stages,
                                              input int unsigned word);
        return (32'd1 << stages) + word;
    endfunction

    // Next phase of a stage that advances and has not reached its last phase.
    function automatic cell_phase_t phase_step(input cell_phase_t ph);
        case (ph)
            PH_0:    return PH_1;
            PH_1:    return PH_2;
            default: return PH_0;
        endcase
    endfunction

endpackage

// File: rtl/mmd_cell.sv
module mmd_cell
    import mmd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick_in,   // one-cycle enable per input period of this stage
    input  logic mod_in,    // stretch window from the slower neighbour
    input  logic prog_bit,  // held program bit of this stage
    output logic tick_out,  // enable for the slower neighbour
    output logic mod_out    // stretch window for the faster neighbour
);

    cell_phase_t ph_q;
    cell_phase_t ph_d;
    cell_phase_t last_ph;
    logic        at_last;

    // Three ticks only when both the window and the program bit are set.
    always_comb begin
        last_ph = (mod_in && prog_bit) ? PH_2 : PH_1;
        at_last = (ph_q == last_ph);
    end

    assign tick_out = tick_in && at_last;
    assign mod_out  = mod_in && at_last;

    always_comb begin
        if (!tick_in) begin
            ph_d = ph_q;
        end else if (at_last) begin
            ph_d = PH_0;
        end else begin
            ph_d = phase_step(ph_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= PH_0;
        end else begin
            ph_q <= ph_d;
        end
    end

endmodule

// File: rtl/mmd_cell_chain.sv
module mmd_cell_chain #(
    parameter int STAGES = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAGES-1:0] word,
    output logic              cycle_end,
    output logic              chain_wrap
);

    // tick[i]: enable of stage i; modc[i]: modulus-in of stage i-1 (out of stage i).
    logic [STAGES:0] tick;
    logic [STAGES:0] modc;

    assign tick[0]      = 1'b1;
    assign modc[STAGES] = 1'b1;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        mmd_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .tick_in  (tick[i]),
            .mod_in   (modc[i+1]),
            .prog_bit (word[i]),
            .tick_out (tick[i+1]),
            .mod_out  (modc[i])
        );
    end

    assign cycle_end  = modc[0];
    assign chain_wrap = tick[STAGES];

endmodule

// File: rtl/mmd_word_hold.sv
module mmd_word_hold #(
    parameter int STAGES = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [STAGES-1:0] prog,
    output logic [STAGES-1:0] word_q
);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            word_q <= prog;
        end
    end

endmodule

// File: rtl/mmd_out_stage.sv
module mmd_out_stage (
    input  logic clk,
    input  logic rst,
    input  logic cycle_end,
    output logic div_out
);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_out <= 1'b0;
        end else begin
            div_out <= cycle_end;
        end
    end

endmodule

// File: rtl/mmd_divider.sv
module mmd_divider #(
    parameter int STAGES = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAGES-1:0] prog,
    output logic              div_out
);

    logic [STAGES-1:0] word_q;
    logic              cycle_end;
    logic              chain_wrap;

    mmd_word_hold #(.STAGES(STAGES)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .load   (cycle_end),
        .prog   (prog),
        .word_q (word_q)
    );

    mmd_cell_chain #(.STAGES(STAGES)) u_chain (
        .clk        (clk),
        .rst        (rst),
        .word       (word_q),
        .cycle_end  (cycle_end),
        .chain_wrap (chain_wrap)
    );

    mmd_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .cycle_end (cycle_end),
        .div_out   (div_out)
    );

endmodule

// File: rtl/mmd_divider_chk.sv
module mmd_divider_chk #(
    parameter int STAGES = 5
) (
    input logic              clk,
    input logic              rst,
    input logic [STAGES-1:0] prog,
    input logic              div_out,
    input logic              cycle_end,
    input logic              chain_wrap,
    input logic [STAGES-1:0] word_q
);

    localparam int CW = STAGES + 2;
    localparam logic [CW-1:0] BASE = CW'(1) << STAGES;

    logic [CW-1:0] cnt;
    logic [CW-1:0] ratio_q;

    // Independent period model: cycle position and the ratio sampled at its start.
    always_ff @(posedge clk) begin
        if (rst || cycle_end) begin
            cnt     <= CW'(1);
            ratio_q <= BASE + CW'(prog);
        end else begin
            cnt     <= cnt + CW'(1);
        end
    end

    assert_period_R1: assert property (@(posedge clk) disable iff (rst)
        cycle_end |-> (cnt == ratio_q));

    assert_no_overrun_R1: assert property (@(posedge clk) disable iff (rst)
        cnt <= ratio_q);

    assert_one_wide_R2: assert property (@(posedge clk) disable iff (rst)
        div_out |=> !div_out);

    assert_quiet_in_reset_R3: assert property (@(posedge clk)
        rst |=> !div_out);

    assert_word_held_R4: assert property (@(posedge clk) disable iff (rst)
        !cycle_end |=> $stable(word_q));

    assert_word_loaded_R4: assert property (@(posedge clk) disable iff (rst)
        cycle_end |=> (word_q == $past(prog)));

    assert_wrap_align_R8: assert property (@(posedge clk) disable iff (rst)
        cycle_end == chain_wrap);

endmodule

bind mmd_divider mmd_divider_chk #(.STAGES(STAGES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .prog       (prog),
    .div_out    (div_out),
    .cycle_end  (cycle_end),
    .chain_wrap (chain_wrap),
    .word_q     (word_q)
);

// File: tb/mmd_divider_test.sv
module mmd_divider_test;

    localparam int ST    = 5;
    localparam int N_MIN = 1 << ST;

    logic          clk  = 1'b0;
    logic          rst  = 1'b1;
    logic [ST-1:0] prog = '0;
    logic          div_out;

    int total = 0;
    int bad   = 0;
    int act   = 0;
    bit done  = 1'b0;

    mmd_divider #(.STAGES(ST)) uut (
        .clk     (clk),
        .rst     (rst),
        .prog    (prog),
        .div_out (div_out)
    );

    always #10 clk = ~clk;

    function automatic int exp_ratio(input int p);
        return N_MIN + p;
    endfunction

    function automatic string tag_for(input int p);
        if (p == 0) return "R5";
        if (p == N_MIN - 1) return "R6";
        if ((p & (p - 1)) == 0) return "R7";
        return "R1";
    endfunction

    task automatic chk(input string req, input int got, input int want, input string what);
        total++;
        if (got != want) begin
            bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, want);
        end
    endtask

    // Count rising edges until the pulse is seen; starts at a negedge.
    task automatic wait_pulse(input int start, output int gap);
        bit seen = 1'b0;
        gap = start;
        while (!seen) begin
            @(posedge clk);
            gap++;
            @(negedge clk);
            if (start == 0 && gap == 1) chk("R2", int'(div_out), 0, "cycle after pulse");
            if (div_out) begin
                seen = 1'b1;
            end else if (gap > 4 * N_MIN) begin
                chk("R1", gap, -1, "no pulse");
                seen = 1'b1;
            end
        end
    endtask

    // One full period: checks R1 and, through it, the stage handshake of R8.
    task automatic run_period();
        int g;
        wait_pulse(0, g);
        chk(tag_for(act), g, exp_ratio(act), "period length");
        act = int'(prog);
    endtask

    task automatic do_reset(input int p);
        int g;
        @(negedge clk);
        rst  = 1'b1;
        prog = ST'(p);
        repeat (3) @(negedge clk);
        chk("R3", int'(div_out), 0, "output during reset");
        rst = 1'b0;
        act = p;
        wait_pulse(0, g);
        chk("R3", g, exp_ratio(p), "first pulse after reset");
    endtask

    task automatic mid_change(input int r, input int newp);
        int g;
        int old;
        old = act;
        repeat (r) @(negedge clk);
        prog = ST'(newp);
        wait_pulse(r, g);
        chk("R4", g, exp_ratio(old), "period in flight after change");
        act = int'(prog);
        wait_pulse(0, g);
        chk("R4", g, exp_ratio(newp), "period after change");
        act = int'(prog);
    endtask

    initial begin
        void'($urandom(32'd4242));
        do_reset(3);

        // Full sweep of every program word (R1, R5, R6, R7).
        for (int p = 0; p < N_MIN; p++) begin
            prog = ST'(p);
            run_period();
            run_period();
        end

        // Directed boundary: change in the very last cycle of the period (R4).
        prog = ST'(0);
        run_period();
        run_period();
        mid_change(exp_ratio(act) - 1, N_MIN - 1);
        mid_change(exp_ratio(act) - 1, 1);
        mid_change(1, 16);

        // Random mid-cycle changes (R4).
        for (int k = 0; k < 30; k++) begin
            mid_change(int'($urandom_range(1, N_MIN - 1)), int'($urandom_range(0, N_MIN - 1)));
        end

        // Random words applied right after a pulse (R1).
        for (int k = 0; k < 20; k++) begin
            prog = ST'($urandom_range(0, N_MIN - 1));
            run_period();
            run_period();
        end

        // Reset in the middle of a cycle (R3) with the largest ratio.
        repeat (7) @(negedge clk);
        do_reset(N_MIN - 1);
        run_period();

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL R1 watchdog: actual %0d expected %0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule